// File: doc/BRIEF.md
# Word and Byte Access SPI Data FIFO

This block sits between a 32-bit register port and a byte-serial SPI shift engine. It holds one byte-wide queue for transmit data and one for receive data. Software can load the transmit queue one whole 32-bit word at a time or one byte at a time. It can unload the receive queue the same two ways. The shift engine takes transmit bytes one per strobe and delivers received bytes one per strobe.

Four sticky status flags report the queues to software:

- transmit queue empty
- at least four received bytes waiting
- at least one received byte waiting
- an access error, meaning a push into a full queue or a pop from an empty one

Software clears flags by writing ones to a clear mask. A typical driver clears a flag and then polls it.

A soft reset input empties both queues and drops every flag. The block does not drive the SPI pins.

Top module: `spi_word_fifo`

## Requirements
- R1: The transmit queue holds TX_DEPTH bytes (64 by default, i.e. 16 words). A word push that does not fit completely is dropped as a whole, and the queue content is unchanged.
- R2: A cycle with `pushWord` high appends `wrData` as four bytes: bits 7:0 first, then 15:8, then 23:16, then 31:24. A cycle with `pushByte` high appends only `wrData[7:0]`. Bytes leave on `txByte` in the order they were appended.
- R3: `rdData[7:0]` is always the oldest received byte. With four or more bytes present, `rdData` packs the four oldest bytes, the oldest in bits 7:0. `popWord` removes four bytes. `popByte` removes one byte.
- R4: Status bit 0 (transmit empty) is set one cycle after the transmit queue level reaches zero, and stays set until it is cleared.
- R5: Status bit 2 (byte available) is set one cycle after the receive queue holds at least one byte.
- R6: Status bit 1 (word available) is set one cycle after the receive queue holds at least four bytes. It stays clear while fewer than four bytes are present.
- R7: A cycle with `clrWr` high clears every status bit whose `clrMask` bit is one and leaves the other bits unchanged.
  - A cleared flag whose condition still holds in that cycle reads set again afterwards, so a poll after a clear shows the live condition.
  - A clear with mask 4'b1111 clears every flag.
- R8: Status bit 3 (error) is sticky. Any of the following accesses is ignored and sets it:
  - a word push without room for four bytes;
  - a byte push into a full transmit queue;
  - `txTake` while the transmit queue is empty;
  - `popWord` with fewer than four bytes present;
  - `popByte` with no byte present.
- R9: Reset and `softRst` both empty both queues and clear all status bits. In the cycle after `softRst` the status reads zero and `txValid` is low.
- R10: When `pushWord` and `pushByte` are high together, only the word is appended. When `popWord` and `popByte` are high together, only the word pop is performed.
- R11: `txValid` is high whenever the transmit queue is not empty, with `txByte` showing its oldest byte. An `rxStrobe` while the receive queue is full drops `rxByte` and sets status bit 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| softRst | input | 1 | Synchronous flush of both queues and all flags |
| pushWord | input | 1 | Append four bytes of wrData to the transmit queue |
| pushByte | input | 1 | Append wrData[7:0] to the transmit queue |
| wrData | input | 32 | Write data from the register port |
| popWord | input | 1 | Remove four bytes from the receive queue |
| popByte | input | 1 | Remove one byte from the receive queue |
| rdData | output | 32 | Oldest receive bytes, oldest in bits 7:0 |
| clrWr | input | 1 | Apply clrMask as a write-one-to-clear |
| clrMask | input | 4 | Flags to clear |
| status | output | 4 | {error, rxByteAvail, rxWordAvail, txEmpty} |
| txByte | output | 8 | Oldest transmit byte for the shift engine |
| txValid | output | 1 | Transmit queue not empty |
| txTake | input | 1 | Shift engine consumes txByte |
| rxByte | input | 8 | Byte from the shift engine |
| rxStrobe | input | 1 | Append rxByte to the receive queue |

## Verification
The hardest situation to reach is the exact boundary of a full queue. This means a seventeenth word push, or a sixty-fifth received byte, arriving when every slot is occupied, and the proof that it left no trace. The stimulus fills each queue completely through its normal ports and attempts the extra access. It then drains every byte and compares the drained sequence with a bench model. A leftover byte or a missing byte would show up in that sequence. The clear-then-poll behaviour is reached by clearing a flag once while its condition is false and once while it is still true.

// File: rtl/swf_pkg.sv
package swf_pkg;
  localparam int FLAG_TX_EMPTY = 0;
  localparam int FLAG_RX_WORD  = 1;
  localparam int FLAG_RX_BYTE  = 2;
  localparam int FLAG_ERROR    = 3;
  localparam int NUM_FLAGS     = 4;
  localparam int WORD_BYTES    = 4;

  // Strobes from control to datapath, already qualified against levels
  typedef struct packed {
    logic       flush;
    logic [2:0] txPushCnt;
    logic       txPop;
    logic       rxPush;
    logic [2:0] rxPopCnt;
  } swf_strobe_t;
endpackage

// File: rtl/swf_byte_fifo.sv
module swf_byte_fifo #(
  parameter int DEPTH    = 64,
  parameter int WR_BYTES = 4,
  parameter int RD_BYTES = 1,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  flush,
  input  logic [2:0]            pushCnt,
  input  logic [8*WR_BYTES-1:0] pushData,
  input  logic [2:0]            popCnt,
  output logic [8*RD_BYTES-1:0] peek,
  output logic [CW-1:0]         level
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    for (int i = 0; i < WR_BYTES; i++) begin
      if (!flush && (3'(i) < pushCnt)) mem[wrPtr + AW'(i)] <= pushData[8*i +: 8];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      wrPtr <= wrPtr + AW'(pushCnt);
      rdPtr <= rdPtr + AW'(popCnt);
      level <= level + CW'(pushCnt) - CW'(popCnt);
    end
  end

  for (genvar g = 0; g < RD_BYTES; g++) begin : gPeek
    assign peek[8*g +: 8] = mem[rdPtr + AW'(g)];
  end
endmodule

// File: rtl/swf_datapath.sv
module swf_datapath
  import swf_pkg::*;
#(
  parameter int TX_DEPTH = 64,
  parameter int RX_DEPTH = 64,
  localparam int TX_CW = $clog2(TX_DEPTH) + 1,
  localparam int RX_CW = $clog2(RX_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  swf_strobe_t       strobe,
  input  logic [31:0]       wrData,
  input  logic [7:0]        rxByte,
  output logic [7:0]        txHead,
  output logic [31:0]       rxHead,
  output logic [TX_CW-1:0]  txLevel,
  output logic [RX_CW-1:0]  rxLevel
);
  swf_byte_fifo #(.DEPTH(TX_DEPTH), .WR_BYTES(WORD_BYTES), .RD_BYTES(1)) uTx (
    .clk(clk), .rstN(rstN), .flush(strobe.flush),
    .pushCnt(strobe.txPushCnt), .pushData(wrData),
    .popCnt({2'b00, strobe.txPop}), .peek(txHead), .level(txLevel)
  );

  swf_byte_fifo #(.DEPTH(RX_DEPTH), .WR_BYTES(1), .RD_BYTES(WORD_BYTES)) uRx (
    .clk(clk), .rstN(rstN), .flush(strobe.flush),
    .pushCnt({2'b00, strobe.rxPush}), .pushData(rxByte),
    .popCnt(strobe.rxPopCnt), .peek(rxHead), .level(rxLevel)
  );
endmodule

// File: rtl/swf_ctrl.sv
module swf_ctrl
  import swf_pkg::*;
#(
  parameter int TX_DEPTH = 64,
  parameter int RX_DEPTH = 64,
  localparam int TX_CW = $clog2(TX_DEPTH) + 1,
  localparam int RX_CW = $clog2(RX_DEPTH) + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 softRst,
  input  logic                 pushWord,
  input  logic                 pushByte,
  input  logic                 popWord,
  input  logic                 popByte,
  input  logic                 txTake,
  input  logic                 rxStrobe,
  input  logic                 clrWr,
  input  logic [NUM_FLAGS-1:0] clrMask,
  input  logic [TX_CW-1:0]     txLevel,
  input  logic [RX_CW-1:0]     rxLevel,
  output swf_strobe_t          strobe,
  output logic [NUM_FLAGS-1:0] status
);
  logic txWordRoom, txByteRoom, rxWordHave, rxByteHave, rxFull, txHave;
  logic errEvt;
  logic [NUM_FLAGS-1:0] setBits, clrBits;

  assign txWordRoom = txLevel <= TX_CW'(TX_DEPTH - WORD_BYTES);
  assign txByteRoom = txLevel <  TX_CW'(TX_DEPTH);
  assign txHave     = txLevel != '0;
  assign rxWordHave = rxLevel >= RX_CW'(WORD_BYTES);
  assign rxByteHave = rxLevel != '0;
  assign rxFull     = rxLevel == RX_CW'(RX_DEPTH);

  always_comb begin
    strobe = '0;
    strobe.flush = softRst;
    if (!softRst) begin
      if (pushWord)      strobe.txPushCnt = txWordRoom ? 3'd4 : 3'd0;
      else if (pushByte) strobe.txPushCnt = txByteRoom ? 3'd1 : 3'd0;
      strobe.txPop  = txTake && txHave;
      strobe.rxPush = rxStrobe && !rxFull;
      if (popWord)      strobe.rxPopCnt = rxWordHave ? 3'd4 : 3'd0;
      else if (popByte) strobe.rxPopCnt = rxByteHave ? 3'd1 : 3'd0;
    end
  end

  assign errEvt = (pushWord && !txWordRoom)
               || (!pushWord && pushByte && !txByteRoom)
               || (txTake && !txHave)
               || (rxStrobe && rxFull)
               || (popWord && !rxWordHave)
               || (!popWord && popByte && !rxByteHave);

  always_comb begin
    setBits = '0;
    setBits[FLAG_TX_EMPTY] = !txHave;
    setBits[FLAG_RX_WORD]  = rxWordHave;
    setBits[FLAG_RX_BYTE]  = rxByteHave;
    setBits[FLAG_ERROR]    = errEvt;
  end

  assign clrBits = clrWr ? clrMask : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        status <= '0;
    else if (softRst) status <= '0;
    else              status <= (status & ~clrBits) | setBits;
  end
endmodule

// File: rtl/spi_word_fifo.sv
module spi_word_fifo
  import swf_pkg::*;
#(
  parameter int TX_DEPTH = 64,
  parameter int RX_DEPTH = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        softRst,
  input  logic        pushWord,
  input  logic        pushByte,
  input  logic [31:0] wrData,
  input  logic        popWord,
  input  logic        popByte,
  output logic [31:0] rdData,
  input  logic        clrWr,
  input  logic [3:0]  clrMask,
  output logic [3:0]  status,
  output logic [7:0]  txByte,
  output logic        txValid,
  input  logic        txTake,
  input  logic [7:0]  rxByte,
  input  logic        rxStrobe
);
  localparam int TX_CW = $clog2(TX_DEPTH) + 1;
  localparam int RX_CW = $clog2(RX_DEPTH) + 1;

  swf_strobe_t      strobe;
  logic [TX_CW-1:0] txLevel;
  logic [RX_CW-1:0] rxLevel;

  swf_ctrl #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .softRst(softRst),
    .pushWord(pushWord), .pushByte(pushByte),
    .popWord(popWord), .popByte(popByte),
    .txTake(txTake), .rxStrobe(rxStrobe),
    .clrWr(clrWr), .clrMask(clrMask),
    .txLevel(txLevel), .rxLevel(rxLevel),
    .strobe(strobe), .status(status)
  );

  swf_datapath #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrData(wrData), .rxByte(rxByte),
    .txHead(txByte), .rxHead(rdData),
    .txLevel(txLevel), .rxLevel(rxLevel)
  );

  assign txValid = txLevel != '0;
endmodule

// File: rtl/swf_checker.sv
module swf_checker #(
  parameter int TX_DEPTH = 64,
  parameter int RX_DEPTH = 64,
  localparam int TX_CW = $clog2(TX_DEPTH) + 1,
  localparam int RX_CW = $clog2(RX_DEPTH) + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             softRst,
  input logic             pushWord,
  input logic             txTake,
  input logic             clrWr,
  input logic [3:0]       clrMask,
  input logic [3:0]       status,
  input logic [TX_CW-1:0] txLevel,
  input logic [RX_CW-1:0] rxLevel
);
  AST_NO_TX_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    int'(txLevel) <= TX_DEPTH); // R1
  AST_NO_RX_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    int'(rxLevel) <= RX_DEPTH); // R11
  AST_WORD_PUSH_ADDS_FOUR: assert property (@(posedge clk) disable iff (!rstN)
    (pushWord && !txTake && !softRst && int'(txLevel) <= TX_DEPTH - 4)
    |=> int'(txLevel) == int'($past(txLevel)) + 4); // R2
  AST_TX_EMPTY_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (txLevel == '0 && !softRst) |=> status[0]); // R4
  AST_RX_BYTE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (rxLevel != '0 && !softRst) |=> status[2]); // R5
  AST_RX_WORD_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (int'(rxLevel) >= 4 && !softRst) |=> status[1]); // R6
  AST_ERROR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (status[3] && !softRst && !(clrWr && clrMask[3])) |=> status[3]); // R8
  AST_SOFT_RESET_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (status == 4'b0000 && txLevel == '0 && rxLevel == '0)); // R9
endmodule

bind spi_word_fifo swf_checker #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) uChk (
  .clk(clk), .rstN(rstN), .softRst(softRst), .pushWord(pushWord),
  .txTake(txTake), .clrWr(clrWr), .clrMask(clrMask), .status(status),
  .txLevel(txLevel), .rxLevel(rxLevel)
);

// File: tb/sim_spi_word_fifo.sv
module sim_spi_word_fifo;
  localparam time CLK_HALF = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        softRst = 1'b0, pushWord = 1'b0, pushByte = 1'b0;
  logic [31:0] wrData = '0;
  logic        popWord = 1'b0, popByte = 1'b0;
  logic [31:0] rdData;
  logic        clrWr = 1'b0;
  logic [3:0]  clrMask = '0;
  logic [3:0]  status;
  logic [7:0]  txByte;
  logic        txValid;
  logic        txTake = 1'b0;
  logic [7:0]  rxByte = '0;
  logic        rxStrobe = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [7:0] txModel[$];

  // bit 32 selects a word push, otherwise a byte push of bits 7:0
  localparam logic [32:0] VEC [6] = '{
    {1'b1, 32'h4433_2211}, {1'b0, 32'hFFFF_FFA5}, {1'b1, 32'hDEAD_BEEF},
    {1'b0, 32'h0000_003C}, {1'b1, 32'h0102_0304}, {1'b0, 32'h1234_5677}
  };

  always #CLK_HALF clk = ~clk;

  spi_word_fifo u0 (
    .clk(clk), .rstN(rstN), .softRst(softRst), .pushWord(pushWord),
    .pushByte(pushByte), .wrData(wrData), .popWord(popWord), .popByte(popByte),
    .rdData(rdData), .clrWr(clrWr), .clrMask(clrMask), .status(status),
    .txByte(txByte), .txValid(txValid), .txTake(txTake),
    .rxByte(rxByte), .rxStrobe(rxStrobe)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic doPushWord(logic [31:0] d);
    pushWord = 1'b1; wrData = d; tick(); pushWord = 1'b0;
  endtask

  task automatic doPushByte(logic [31:0] d);
    pushByte = 1'b1; wrData = d; tick(); pushByte = 1'b0;
  endtask

  task automatic doClear(logic [3:0] m);
    clrWr = 1'b1; clrMask = m; tick(); clrWr = 1'b0; clrMask = '0;
  endtask

  task automatic rxFeed(logic [7:0] b);
    rxStrobe = 1'b1; rxByte = b; tick(); rxStrobe = 1'b0;
  endtask

  task automatic doPopWord();
    popWord = 1'b1; tick(); popWord = 1'b0;
  endtask

  task automatic doPopByte();
    popByte = 1'b1; tick(); popByte = 1'b0;
  endtask

  task automatic drainModel(string req);
    while (txModel.size() != 0) begin
      logic [7:0] e;
      e = txModel.pop_front();
      check({req, " txValid"}, {31'b0, txValid}, 32'd1);
      check({req, " txByte"}, {24'b0, txByte}, {24'b0, e});
      txTake = 1'b1; tick(); txTake = 1'b0;
    end
  endtask

  task automatic finishUp();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finishUp();
  end

  initial begin
    repeat (3) tick();
    check("R9 reset status", {28'b0, status}, 32'h0);
    check("R9 reset txValid", {31'b0, txValid}, 32'h0);
    rstN = 1'b1;
    tick();
    check("R4 empty after reset", {28'b0, status}, 32'h1);

    // table walk: mixed word and byte pushes
    for (int i = 0; i < 6; i++) begin
      if (VEC[i][32]) begin
        doPushWord(VEC[i][31:0]);
        for (int b = 0; b < 4; b++) txModel.push_back(VEC[i][8*b +: 8]);
      end else begin
        doPushByte(VEC[i][31:0]);
        txModel.push_back(VEC[i][7:0]);
      end
    end
    doClear(4'b0001);
    check("R7 clear txEmpty while filled", {28'b0, status}, 32'h0);
    drainModel("R2");
    check("R4 flag not yet set", {31'b0, status[0]}, 32'h0);
    tick();
    check("R4 txEmpty after drain", {31'b0, status[0]}, 32'h1);
    check("R11 txValid low when empty", {31'b0, txValid}, 32'h0);
    doClear(4'b0001);
    check("R7 live condition after clear", {28'b0, status}, 32'h1);

    // R10 simultaneous pushes
    pushWord = 1'b1; pushByte = 1'b1; wrData = 32'hA1B2_C3D4; tick();
    pushWord = 1'b0; pushByte = 1'b0;
    for (int b = 0; b < 4; b++) txModel.push_back(8'(32'hA1B2_C3D4 >> (8*b)));
    drainModel("R10");
    check("R10 no extra byte", {31'b0, txValid}, 32'h0);

    // R1 / R8 transmit overflow
    for (int w = 0; w < 16; w++) begin
      logic [31:0] d;
      d = {8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)};
      doPushWord(d);
      for (int b = 0; b < 4; b++) txModel.push_back(d[8*b +: 8]);
    end
    check("R8 no error when exactly full", {31'b0, status[3]}, 32'h0);
    doPushWord(32'hEEEE_EEEE);
    check("R8 error on full word push", {31'b0, status[3]}, 32'h1);
    doPushByte(32'h0000_00EE);
    drainModel("R1");
    check("R1 overflow pushes dropped", {31'b0, txValid}, 32'h0);
    doClear(4'b1000);
    check("R7 clear error only", {28'b0, status}, 32'h1);
    txTake = 1'b1; tick(); txTake = 1'b0;
    check("R8 error on empty take", {31'b0, status[3]}, 32'h1);
    doClear(4'b1111);
    check("R7 clear all keeps live txEmpty", {28'b0, status}, 32'h1);

    // receive flags and word/byte pops
    rxFeed(8'h11); rxFeed(8'h22); rxFeed(8'h33);
    tick();
    check("R5 byte available", {31'b0, status[2]}, 32'h1);
    check("R6 word not yet available", {31'b0, status[1]}, 32'h0);
    rxFeed(8'h44);
    tick();
    check("R6 word available", {31'b0, status[1]}, 32'h1);
    check("R3 word packing", rdData, 32'h4433_2211);
    doPopWord();
    doPopByte();
    check("R8 error on empty byte pop", {31'b0, status[3]}, 32'h1);
    doClear(4'b1110);
    check("R7 rx flags clear when empty", {28'b0, status}, 32'h1);
    rxFeed(8'h55); rxFeed(8'h66);
    check("R3 oldest byte", {24'b0, rdData[7:0]}, 32'h55);
    doPopByte();
    check("R3 byte pop advances", {24'b0, rdData[7:0]}, 32'h66);
    doPopWord();
    check("R8 short word pop ignored", {24'b0, rdData[7:0]}, 32'h66);
    check("R8 error on short word pop", {31'b0, status[3]}, 32'h1);
    doPopByte();
    doClear(4'b1111);

    // R11 receive overflow
    for (int i = 0; i < 64; i++) rxFeed(8'(i));
    check("R11 no error at full", {31'b0, status[3]}, 32'h0);
    rxFeed(8'hFF);
    check("R11 error on full receive", {31'b0, status[3]}, 32'h1);
    for (int w = 0; w < 16; w++) begin
      check("R3 full queue word order", rdData,
            {8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)});
      doPopWord();
    end
    doClear(4'b1000);
    doPopByte();
    check("R11 dropped byte absent", {31'b0, status[3]}, 32'h1);
    doClear(4'b1111);

    // R9 soft reset
    doPushWord(32'h0BAD_F00D);
    rxFeed(8'h77); rxFeed(8'h88);
    tick();
    softRst = 1'b1; tick(); softRst = 1'b0;
    check("R9 soft reset status", {28'b0, status}, 32'h0);
    check("R9 soft reset tx empty", {31'b0, txValid}, 32'h0);
    tick();
    check("R4 empty after soft reset", {28'b0, status}, 32'h1);
    doPopByte();
    check("R9 rx emptied", {31'b0, status[3]}, 32'h1);

    finishUp();
  end
endmodule